// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block ranks a set of interrupt request lines by programmable 8-bit priority values and decides which handler the processor runs next. A global split field divides every priority into an upper preemption group and a lower sub-priority. Only the group decides whether a new request may interrupt the handler that is already running. Sub-priority and line index only break ties between requests that are waiting at the same time. Preempted handlers are kept on an internal stack, and they are resumed in last-in, first-out order.

The controller also counts the processor's context-switch costs in clock cycles. A fresh entry costs 12 cycles. A full exit followed by a new entry costs 24 cycles. When another request is already waiting as a handler returns, a 6-cycle tail-chain replaces the full exit and entry. The controller raises a one-cycle start pulse when a handler's first instruction may run. A global mask holds off every new entry until it is released.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `in_handler` is 0, `exec_prio` is all ones, `handler_start` is 0 and `active_vec` is 0.
- R2: A numerically smaller priority value is more urgent. Of several lines that become pending together at an idle controller, the line with the smallest value is taken first.
- R3: A pending request preempts the running handler only when its group value is strictly smaller than the group of the running handler. An equal group waits for the handler to return.
- R4: Among pending requests in the same group, the smaller sub-priority is taken first.
- R5: When group and sub-priority are both equal, the smaller line index is taken first.
- R6: With `group_sel` = g, the low g bits of a priority are sub-priority for g in 0..6. For g = 7, all 8 bits are sub-priority, so the group value is always 0 and no request ever preempts.
- R7: With `group_sel` = 0, every bit is group, so any strictly smaller value preempts.
- R8: A request line is captured on the clock edge that first samples it high. With the mask clear, `handler_start` is seen high exactly 12 edges after the capture edge, and it lasts one cycle.
- R9: While `mask_all` is high, no handler is entered. `handler_start` is seen high 12 edges after the last edge that sampled `mask_all` high.
- R10: If `handler_ret` is sampled while an eligible request waits, the controller tail-chains. `handler_start` follows 6 edges after the return edge, and `active_vec` and `exec_prio` show the new handler.
- R11: A line that is raised again during its own handler stays pending. It is taken only after the full exit, and `handler_start` follows 24 edges after the return edge.
- R12: On a return with nothing eligible waiting, the previous level is popped 12 edges after the return edge. `active_vec` and `exec_prio` go back to the preempted handler with no start pulse, or to idle (`in_handler` 0, `exec_prio` all ones) when the stack is empty.
- R13: `handler_ret` has no effect while no handler is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_IRQ | Request lines, captured on a rising level |
| irq_prio | input | N_IRQ*PRIO_W | Priority of each line, where line i is bits [i*PRIO_W +: PRIO_W] |
| group_sel | input | GRP_W | Split between group and sub-priority bits |
| mask_all | input | 1 | Global hold-off of handler entry |
| handler_ret | input | 1 | One-cycle strobe marking return from the running handler |
| active_vec | output | log2(N_IRQ) | Line index of the running handler |
| handler_start | output | 1 | One-cycle pulse when a handler may begin |
| exec_prio | output | PRIO_W | Priority of the running handler, all ones when idle |
| in_handler | output | 1 | A handler is running |

## Verification
The bench targets the ordering traps. Equal groups with different sub-priority must not preempt. A design that compared full values would nest them. Exact ties must go to the lower index, or the wrong line starts. A split of 7 must freeze nesting, while a split of 0 must preempt on a difference of one. A return must choose between a 6-cycle chain and a 24-cycle exit-plus-entry. A controller that chained to its own re-raised line, or that forgot to pop the stack, would show the wrong start delay or the wrong resumed priority.

// File: rtl/irqn_pkg.sv
package irqn_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTRY = 2'd1,
    ST_CHAIN = 2'd2,
    ST_EXIT  = 2'd3
  } irqn_state_e;

  // number of low priority bits that act as sub-priority for split code g
  function automatic int sub_bits(input int g, input int gmax, input int width);
    if (g >= gmax) return width;
    if (g > width) return width;
    return g;
  endfunction

endpackage

// File: rtl/irqn_pend.sv
module irqn_pend #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] req,
  input  logic [N_IRQ-1:0] clr,
  output logic [N_IRQ-1:0] pend
);

  logic [N_IRQ-1:0] req_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    logic rise;
    assign rise = req[i] & ~req_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        req_q[i] <= req[i];
        pend[i]  <= (pend[i] & ~clr[i]) | rise;
      end
    end

    // R11
    pend_kept_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(pend[i]) |-> $past(clr[i]));
  end

endmodule

// File: rtl/irqn_arb.sv
module irqn_arb #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 8,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IRQ-1:0]        cand,
  input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
  output logic                    win_valid,
  output logic [IDX_W-1:0]        win_idx,
  output logic [PRIO_W-1:0]       win_prio
);

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '1;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && win_valid) begin
      for (int i = 0; i < N_IRQ; i++) begin
        if (cand[i]) begin
          // R2
          win_min_chk: assert (prio_flat[i*PRIO_W +: PRIO_W] >= win_prio);
          // R5
          win_tie_chk: assert (prio_flat[i*PRIO_W +: PRIO_W] != win_prio || i >= int'(win_idx));
        end
      end
    end
  end

endmodule

// File: rtl/irqn_stack.sv
module irqn_stack #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 257,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] top,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  rd_idx;

  assign empty  = (sp == '0);
  assign rd_idx = empty ? '0 : sp - SP_W'(1);
  assign top    = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push && !pop) begin
      sp <= sp + SP_W'(1);
    end else if (pop && !push) begin
      sp <= sp - SP_W'(1);
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(sp) < DEPTH));

  // R12
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int N_IRQ     = 8,
  parameter int PRIO_W    = 8,
  parameter int GRP_W     = 3,
  parameter int ENTRY_CYC = 12,
  parameter int CHAIN_CYC = 6,
  parameter int EXIT_CYC  = 12,
  localparam int IDX_W    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IRQ-1:0]        irq_req,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [GRP_W-1:0]        group_sel,
  input  logic                    mask_all,
  input  logic                    handler_ret,
  output logic [IDX_W-1:0]        active_vec,
  output logic                    handler_start,
  output logic [PRIO_W-1:0]       exec_prio,
  output logic                    in_handler
);
  import irqn_pkg::*;

  localparam int GRP_MAX = (1 << GRP_W) - 1;
  localparam int STACK_D = (1 << PRIO_W) + 1;
  localparam int ENT_W   = IDX_W + PRIO_W;
  localparam int CNT_W   = $clog2(ENTRY_CYC + CHAIN_CYC + EXIT_CYC + 1);

  function automatic logic [PRIO_W-1:0] grp_of(input logic [PRIO_W-1:0] p,
                                               input logic [GRP_W-1:0] g);
    int s;
    s = sub_bits(int'(g), GRP_MAX, PRIO_W);
    if (s >= PRIO_W) return '0;
    return p >> s;
  endfunction

  irqn_state_e        state;
  logic [CNT_W-1:0]   cnt;
  logic               running;
  logic [IDX_W-1:0]   cur_vec;
  logic [PRIO_W-1:0]  cur_prio;
  logic [N_IRQ-1:0]   active;
  logic               start_q;

  logic [N_IRQ-1:0]   pend;
  logic [N_IRQ-1:0]   take_oh;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [PRIO_W-1:0]  win_prio;
  logic [ENT_W-1:0]   stk_top;
  logic               stk_empty;
  logic               stk_push;
  logic               stk_pop;
  logic [IDX_W-1:0]   top_vec;
  logic [PRIO_W-1:0]  top_prio;
  logic [PRIO_W-1:0]  win_grp;
  logic [PRIO_W-1:0]  cur_grp;
  logic [PRIO_W-1:0]  top_grp;
  logic               can_take;
  logic               can_chain;
  logic               ret_now;
  logic               do_take;
  logic               do_chain;

  irqn_pend #(.N_IRQ(N_IRQ)) u_pend (
    .clk  (clk),
    .rst  (rst),
    .req  (irq_req),
    .clr  (take_oh),
    .pend (pend)
  );

  irqn_arb #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .cand      (pend & ~active),
    .prio_flat (irq_prio),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  irqn_stack #(.WIDTH(ENT_W), .DEPTH(STACK_D)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (stk_push),
    .pop   (stk_pop),
    .din   ({cur_vec, cur_prio}),
    .top   (stk_top),
    .empty (stk_empty)
  );

  assign {top_vec, top_prio} = stk_top;
  assign win_grp = grp_of(win_prio, group_sel);
  assign cur_grp = grp_of(cur_prio, group_sel);
  assign top_grp = grp_of(top_prio, group_sel);

  assign can_take  = win_valid && !mask_all && (!running || win_grp < cur_grp);
  assign can_chain = win_valid && !mask_all && (stk_empty || win_grp < top_grp);
  assign ret_now   = (state == ST_RUN) && handler_ret && running;
  assign do_chain  = ret_now && can_chain;
  assign do_take   = (state == ST_RUN) && !ret_now && can_take;
  assign take_oh   = (do_take || do_chain) ? (N_IRQ'(1) << win_idx) : '0;
  assign stk_push  = do_take && running;
  assign stk_pop   = (state == ST_EXIT) && (cnt == '0) && !stk_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      cnt      <= '0;
      running  <= 1'b0;
      cur_vec  <= '0;
      cur_prio <= '1;
      active   <= '0;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (state)
        ST_RUN: begin
          if (ret_now) begin
            active[cur_vec] <= 1'b0;
            if (can_chain) begin
              active[win_idx] <= 1'b1;
              cur_vec  <= win_idx;
              cur_prio <= win_prio;
              state    <= ST_CHAIN;
              cnt      <= CNT_W'(CHAIN_CYC - 1);
            end else begin
              state <= ST_EXIT;
              cnt   <= CNT_W'(EXIT_CYC - 1);
            end
          end else if (can_take) begin
            active[win_idx] <= 1'b1;
            cur_vec  <= win_idx;
            cur_prio <= win_prio;
            running  <= 1'b1;
            state    <= ST_ENTRY;
            cnt      <= CNT_W'(ENTRY_CYC - 2);
          end
        end
        ST_ENTRY, ST_CHAIN: begin
          if (cnt == '0) begin
            start_q <= 1'b1;
            state   <= ST_RUN;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_EXIT: begin
          if (cnt == '0) begin
            state <= ST_RUN;
            if (!stk_empty) begin
              cur_vec  <= top_vec;
              cur_prio <= top_prio;
            end else begin
              running  <= 1'b0;
              cur_vec  <= '0;
              cur_prio <= '1;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign active_vec    = cur_vec;
  assign handler_start = start_q;
  assign exec_prio     = cur_prio;
  assign in_handler    = running;

  // R3
  preempt_strict_chk: assert property (@(posedge clk) disable iff (rst)
    stk_push |=> (cur_grp < top_grp));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && mask_all) |=> (state == ST_RUN || state == ST_EXIT));

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    handler_start |=> !handler_start);

  // R8
  start_in_handler_chk: assert property (@(posedge clk) disable iff (rst)
    handler_start |-> in_handler);

  // R12
  idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !in_handler |-> stk_empty);

  // R13
  ret_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !running && handler_ret && !can_take) |=> (!in_handler && state == ST_RUN));

endmodule

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int PW = 8;

  typedef struct packed {
    logic [2:0] g;
    logic [2:0] ia;
    logic [7:0] pa;
    logic [2:0] ib;
    logic [7:0] pb;
    logic [2:0] win;
  } vec_t;

  // idle arbitration table: two lines raised together, expected first winner
  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{3'd3, 3'd2, 8'h40, 3'd5, 8'h20, 3'd5},  // R2 lower group first
    '{3'd3, 3'd1, 8'h2C, 3'd6, 8'h29, 3'd6},  // R4 same group, lower sub
    '{3'd3, 3'd3, 8'h29, 3'd1, 8'h29, 3'd1},  // R5 full tie, lower index
    '{3'd7, 3'd4, 8'h80, 3'd0, 8'h7F, 3'd0},  // R6 all-sub split orders by value
    '{3'd0, 3'd0, 8'h05, 3'd7, 8'h03, 3'd7},  // R7 all-group split
    '{3'd5, 3'd6, 8'h10, 3'd2, 8'h10, 3'd2},  // R5 tie under another split
    '{3'd2, 3'd7, 8'h01, 3'd3, 8'hF0, 3'd7}   // R2 widely apart
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    irq_req = '0;
  logic [N*PW-1:0] irq_prio;
  logic [2:0]      group_sel = '0;
  logic            mask_all = 1'b0;
  logic            handler_ret = 1'b0;
  logic [2:0]      active_vec;
  logic            handler_start;
  logic [PW-1:0]   exec_prio;
  logic            in_handler;
  logic [PW-1:0]   prio [N];

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) irq_prio[i*PW +: PW] = prio[i];
  end

  irq_nest_ctrl u_irq_nest_ctrl (
    .clk           (clk),
    .rst           (rst),
    .irq_req       (irq_req),
    .irq_prio      (irq_prio),
    .group_sel     (group_sel),
    .mask_all      (mask_all),
    .handler_ret   (handler_ret),
    .active_vec    (active_vec),
    .handler_start (handler_start),
    .exec_prio     (exec_prio),
    .in_handler    (in_handler)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [2:0] g);
    rst = 1'b1;
    irq_req = '0;
    handler_ret = 1'b0;
    mask_all = 1'b0;
    group_sel = g;
    for (int i = 0; i < N; i++) prio[i] = 8'hFF;
    tick();
    tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic pulse_req(input int idx);
    irq_req[idx] = 1'b1;
    tick();
    irq_req[idx] = 1'b0;
  endtask

  task automatic do_ret();
    handler_ret = 1'b1;
    tick();
    handler_ret = 1'b0;
  endtask

  // edges until handler_start is seen, capped
  task automatic wait_start(input int cap, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!handler_start && n < cap);
    if (!handler_start) n = -1;
  endtask

  task automatic count_starts(input int cycles, output int s);
    s = 0;
    for (int k = 0; k < cycles; k++) begin
      tick();
      if (handler_start) s++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int s;
    for (int i = 0; i < N; i++) prio[i] = 8'hFF;

    // R1 reset state
    do_reset(3'd3);
    chk("R1 in_handler", int'(in_handler), 0);
    chk("R1 exec_prio", int'(exec_prio), 255);
    chk("R1 handler_start", int'(handler_start), 0);
    chk("R1 active_vec", int'(active_vec), 0);

    // table walk: idle arbitration, entry timing, tail-chain to the other line
    for (int v = 0; v < NV; v++) begin
      int other;
      do_reset(TBL[v].g);
      prio[TBL[v].ia] = TBL[v].pa;
      prio[TBL[v].ib] = TBL[v].pb;
      irq_req[TBL[v].ia] = 1'b1;
      irq_req[TBL[v].ib] = 1'b1;
      tick();
      irq_req = '0;
      wait_start(40, n);
      chk("R8 entry delay", n, 12);
      chk("R2/R4/R5 winner", int'(active_vec), int'(TBL[v].win));
      chk("R2 exec_prio", int'(exec_prio), int'(prio[TBL[v].win]));
      other = (TBL[v].win == TBL[v].ia) ? int'(TBL[v].ib) : int'(TBL[v].ia);
      do_ret();
      wait_start(40, n);
      chk("R10 chain delay", n, 6);
      chk("R10 chained vector", int'(active_vec), other);
      chk("R10 chained prio", int'(exec_prio), int'(prio[other]));
    end

    // R13 return while idle
    do_reset(3'd3);
    do_ret();
    count_starts(20, s);
    chk("R13 no start", s, 0);
    chk("R13 still idle", int'(in_handler), 0);
    chk("R13 exec_prio", int'(exec_prio), 255);

    // R9 mask holds entry
    do_reset(3'd3);
    prio[4] = 8'h30;
    mask_all = 1'b1;
    pulse_req(4);
    repeat (5) tick();
    chk("R9 masked idle", int'(in_handler), 0);
    mask_all = 1'b0;
    wait_start(40, n);
    chk("R9 delay after mask", n, 12);
    chk("R9 vector", int'(active_vec), 4);

    // R3 nesting, equal group waits, chain, R12 pops
    do_reset(3'd3);
    prio[1] = 8'h40;
    prio[2] = 8'h20;
    prio[3] = 8'h27;
    pulse_req(1);
    wait_start(40, n);
    chk("R8 first entry", n, 12);
    pulse_req(2);
    wait_start(40, n);
    chk("R3 preempt delay", n, 12);
    chk("R3 preempt vector", int'(active_vec), 2);
    pulse_req(3);
    count_starts(15, s);
    chk("R3 equal group no preempt", s, 0);
    chk("R3 still line 2", int'(active_vec), 2);
    do_ret();
    wait_start(40, n);
    chk("R10 chain over stack", n, 6);
    chk("R10 chained line 3", int'(active_vec), 3);
    do_ret();
    count_starts(12, s);
    chk("R12 no start on resume", s, 0);
    chk("R12 resumed vector", int'(active_vec), 1);
    chk("R12 resumed prio", int'(exec_prio), 8'h40);
    chk("R12 still in handler", int'(in_handler), 1);
    do_ret();
    repeat (12) tick();
    chk("R12 idle after last", int'(in_handler), 0);
    chk("R12 idle prio", int'(exec_prio), 255);

    // R11 own line raised again
    do_reset(3'd3);
    prio[4] = 8'h30;
    pulse_req(4);
    wait_start(40, n);
    pulse_req(4);
    count_starts(5, s);
    chk("R11 no self preempt", s, 0);
    do_ret();
    wait_start(60, n);
    chk("R11 full exit then entry", n, 24);
    chk("R11 vector", int'(active_vec), 4);

    // R6 split encoding: g=4 separates 0x10/0x0C, g=5 and g=7 do not
    do_reset(3'd4);
    prio[1] = 8'h10;
    prio[2] = 8'h0C;
    pulse_req(1);
    wait_start(40, n);
    pulse_req(2);
    wait_start(40, n);
    chk("R6 g4 preempts", n, 12);
    chk("R6 g4 vector", int'(active_vec), 2);

    do_reset(3'd5);
    prio[1] = 8'h10;
    prio[2] = 8'h0C;
    pulse_req(1);
    wait_start(40, n);
    pulse_req(2);
    count_starts(20, s);
    chk("R6 g5 no preempt", s, 0);
    chk("R6 g5 vector", int'(active_vec), 1);

    do_reset(3'd7);
    prio[1] = 8'hF0;
    prio[2] = 8'h00;
    pulse_req(1);
    wait_start(40, n);
    pulse_req(2);
    count_starts(20, s);
    chk("R6 g7 no nesting", s, 0);
    chk("R6 g7 vector", int'(active_vec), 1);

    // R7 all-group split preempts on a difference of one
    do_reset(3'd0);
    prio[1] = 8'h05;
    prio[2] = 8'h04;
    pulse_req(1);
    wait_start(40, n);
    pulse_req(2);
    wait_start(40, n);
    chk("R7 preempt by one", n, 12);
    chk("R7 vector", int'(active_vec), 2);

    finish_run();
  end

endmodule